// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and the execution lanes of a multithreaded shader core. Each resident warp has one slot that holds a single decoded instruction: two source register indices and one destination register index. A per-warp scoreboard keeps one pending bit per architectural register. An instruction may issue only when none of the registers it names is pending. Issuing marks the destination pending, and a writeback from the memory or arithmetic pipes clears it again.

In each free issue cycle the scheduler looks at every occupied slot whose registers are all clear. It picks the one that has waited longest and uses a rotating pointer when several have waited equally long. An issue holds the shared datapath for a fixed number of cycles, so a warp that has to wait for a long-latency result never blocks other warps that have independent work. A fetch aimed at a slot that still holds an instruction is refused in the same cycle and the slot keeps its contents.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no instruction issues, every slot is empty (a fetch to any warp is accepted, so `fetch_busy` stays 0) and no register is pending.
- R2: `fetch_busy` is 1 in a cycle when `fetch_valid` targets a warp whose slot is occupied. That fetch is dropped, and the instruction later issued from that slot is the one that was already held there.
- R3: An instruction does not issue while its first source, second source or destination register is pending for its own warp.
- R4: Issuing marks the destination register of that warp pending. A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears the mark. If a writeback and an issue hit the same warp and register in the same cycle, the clear wins.
- R5: Issues are at least ISSUE_CYCLES cycles apart. When eligible work is always present, they are exactly ISSUE_CYCLES cycles apart, and `issue_valid` is a one-cycle pulse.
- R6: Each slot holds an age that is loaded with all ones at fetch and drops by one (stopping at zero) at each issue of another warp. Among eligible slots, the lowest age issues first, whatever the warp index or the pointer.
- R7: Among eligible slots that share the lowest age, the first one found from the warp after the last issued warp, counting upward and wrapping at NUM_WARPS, issues.
- R8: A fetch sampled at clock edge n into an idle scheduler with no pending operands issues at edge n+1. A writeback sampled at edge n that releases the only blocked warp lets it issue at edge n+1.
- R9: The scoreboard is per warp. A warp with clear registers issues while another warp waits on a pending register, even if the two warps use the same register index.
- R10: An issue presents the warp index and that warp's buffered src0, src1 and dst fields on the `issue_*` outputs. These outputs are registered and valid in the cycle that `issue_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Write a decoded instruction into a warp slot |
| fetch_warp | input | WW | Target warp of the fetch |
| fetch_src0 | input | RW | First source register index |
| fetch_src1 | input | RW | Second source register index |
| fetch_dst | input | RW | Destination register index |
| fetch_busy | output | 1 | Fetch refused: target slot occupied |
| wb_valid | input | 1 | Writeback clears a pending register |
| wb_warp | input | WW | Warp of the writeback |
| wb_reg | input | RW | Register cleared by the writeback |
| issue_valid | output | 1 | One instruction issued this cycle |
| issue_warp | output | WW | Warp of the issued instruction |
| issue_src0 | output | RW | First source of the issued instruction |
| issue_src1 | output | RW | Second source of the issued instruction |
| issue_dst | output | RW | Destination of the issued instruction |

## Verification
Timing through the block is fixed. `fetch_busy` responds in the same cycle as the fetch, so the bench reads it a fraction of a cycle after driving the inputs. A fetch or a releasing writeback driven before edge n shows up on `issue_valid` just after edge n+1. Issue events are logged one time unit after each rising edge, together with the edge count. Every latency, spacing and order check is then an exact comparison against an edge number the bench works out from the cycle in which it drove the stimulus. Checks that something must not issue wait ten cycles and count the logged issues, and the age and rotation checks use a fixed four-warp setup whose order is worked out by hand.

// File: rtl/wis_pkg.sv
package wis_pkg;

  // Increment with wrap at n (round-robin pointer advance).
  function automatic int unsigned wis_wrap_inc(int unsigned v, int unsigned n);
    return ((v + 1) >= n) ? 0 : (v + 1);
  endfunction

endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
  parameter int NW = 24,
  parameter int NR = 16,
  localparam int WW = (NW > 1) ? $clog2(NW) : 1,
  localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [WW-1:0]          set_warp,
  input  logic [RW-1:0]          set_reg,
  input  logic                   clr_en,
  input  logic [WW-1:0]          clr_warp,
  input  logic [RW-1:0]          clr_reg,
  output logic [NW-1:0][NR-1:0]  pend
);

  logic [NW-1:0][NR-1:0] pend_q, pend_d;
  logic                  upd_en;

  assign upd_en = set_en | clr_en;

  always_comb begin
    pend_d = pend_q;
    if (set_en) pend_d[set_warp][set_reg] = 1'b1;
    if (clr_en) pend_d[clr_warp][clr_reg] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R4
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !pend_q[$past(clr_warp)][$past(clr_reg)]);

  // R4
  issue_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_warp == set_warp && clr_reg == set_reg))
      |=> pend_q[$past(set_warp)][$past(set_reg)]);

endmodule

// File: rtl/wis_slot_buffer.sv
module wis_slot_buffer #(
  parameter int NW = 24,
  parameter int RW = 4,
  parameter int AGE_W = 3,
  localparam int WW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WW-1:0]            wr_warp,
  input  logic [RW-1:0]            wr_src0,
  input  logic [RW-1:0]            wr_src1,
  input  logic [RW-1:0]            wr_dst,
  input  logic                     rel_en,
  input  logic [WW-1:0]            rel_warp,
  output logic [NW-1:0]            occ,
  output logic [NW-1:0][RW-1:0]    src0,
  output logic [NW-1:0][RW-1:0]    src1,
  output logic [NW-1:0][RW-1:0]    dst,
  output logic [NW-1:0][AGE_W-1:0] age
);

  logic [NW-1:0]            occ_q, occ_d;
  logic [NW-1:0][RW-1:0]    s0_q, s0_d, s1_q, s1_d, d_q, d_d;
  logic [NW-1:0][AGE_W-1:0] age_q, age_d;
  logic                     upd_en;

  assign upd_en = wr_en | rel_en;

  always_comb begin
    occ_d = occ_q;
    s0_d  = s0_q;
    s1_d  = s1_q;
    d_d   = d_q;
    age_d = age_q;
    for (int w = 0; w < NW; w++) begin
      if (rel_en && rel_warp == WW'(w)) begin
        occ_d[w] = 1'b0;
      end else if (rel_en && occ_q[w] && age_q[w] != '0) begin
        age_d[w] = age_q[w] - 1'b1;
      end
      if (wr_en && wr_warp == WW'(w) && !occ_q[w]) begin
        occ_d[w] = 1'b1;
        s0_d[w]  = wr_src0;
        s1_d[w]  = wr_src1;
        d_d[w]   = wr_dst;
        age_d[w] = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      s0_q  <= '0;
      s1_q  <= '0;
      d_q   <= '0;
      age_q <= '0;
    end else if (upd_en) begin
      occ_q <= occ_d;
      s0_q  <= s0_d;
      s1_q  <= s1_d;
      d_q   <= d_d;
      age_q <= age_d;
    end
  end

  assign occ  = occ_q;
  assign src0 = s0_q;
  assign src1 = s1_q;
  assign dst  = d_q;
  assign age  = age_q;

  // R2
  write_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !occ_q[wr_warp]);

  for (genvar g = 0; g < NW; g++) begin : g_hold
    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q[g] && !(rel_en && rel_warp == WW'(g)))
        |=> (occ_q[g] && s0_q[g] == $past(s0_q[g]) && s1_q[g] == $past(s1_q[g])
             && d_q[g] == $past(d_q[g])));
  end

endmodule

// File: rtl/wis_picker.sv
module wis_picker
  import wis_pkg::*;
#(
  parameter int NW = 24,
  parameter int NR = 16,
  parameter int AGE_W = 3,
  localparam int WW = (NW > 1) ? $clog2(NW) : 1,
  localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [NW-1:0]            occ,
  input  logic [NW-1:0][RW-1:0]    src0,
  input  logic [NW-1:0][RW-1:0]    src1,
  input  logic [NW-1:0][RW-1:0]    dst,
  input  logic [NW-1:0][AGE_W-1:0] age,
  input  logic [NW-1:0][NR-1:0]    pend,
  output logic                     pick_valid,
  output logic [WW-1:0]            pick_warp
);

  logic [NW-1:0]    elig, cand;
  logic [AGE_W-1:0] best_age;
  logic             found;
  logic [WW-1:0]    sel;
  logic [WW-1:0]    rr_q, rr_d;

  for (genvar g = 0; g < NW; g++) begin : g_elig
    assign elig[g] = occ[g] & ~pend[g][src0[g]] & ~pend[g][src1[g]] & ~pend[g][dst[g]];
  end

  always_comb begin
    best_age = '1;
    for (int w = 0; w < NW; w++) begin
      if (elig[w] && age[w] < best_age) best_age = age[w];
    end
    for (int w = 0; w < NW; w++) begin
      cand[w] = elig[w] && (age[w] == best_age);
    end
  end

  always_comb begin
    int unsigned idx;
    found = 1'b0;
    sel   = '0;
    idx   = 0;
    for (int k = 0; k < NW; k++) begin
      idx = 32'(rr_q) + 32'(k);
      if (idx >= 32'(NW)) idx = idx - 32'(NW);
      if (!found && cand[idx]) begin
        found = 1'b1;
        sel   = WW'(idx);
      end
    end
  end

  assign pick_valid = enable & found;
  assign pick_warp  = sel;
  assign rr_d       = WW'(wis_wrap_inc(32'(sel), 32'(NW)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rr_q <= '0;
    else if (pick_valid) rr_q <= rr_d;
  end

  logic older_seen;
  always_comb begin
    older_seen = 1'b0;
    for (int w = 0; w < NW; w++) begin
      if (elig[w] && age[w] < age[sel]) older_seen = 1'b1;
    end
  end

  // R6
  oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> !older_seen);

  // R3
  operands_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (occ[sel] && !pend[sel][src0[sel]] && !pend[sel][src1[sel]]
                    && !pend[sel][dst[sel]]));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS    = 24,
  parameter int NUM_REGS     = 16,
  parameter int AGE_W        = 3,
  parameter int ISSUE_CYCLES = 4,
  localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [WW-1:0] fetch_warp,
  input  logic [RW-1:0] fetch_src0,
  input  logic [RW-1:0] fetch_src1,
  input  logic [RW-1:0] fetch_dst,
  output logic          fetch_busy,
  input  logic          wb_valid,
  input  logic [WW-1:0] wb_warp,
  input  logic [RW-1:0] wb_reg,
  output logic          issue_valid,
  output logic [WW-1:0] issue_warp,
  output logic [RW-1:0] issue_src0,
  output logic [RW-1:0] issue_src1,
  output logic [RW-1:0] issue_dst
);

  localparam int BW = $clog2(ISSUE_CYCLES + 1);

  logic [NUM_WARPS-1:0]                occ;
  logic [NUM_WARPS-1:0][RW-1:0]        s0, s1, dd;
  logic [NUM_WARPS-1:0][AGE_W-1:0]     age;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend;
  logic                                pick_valid;
  logic [WW-1:0]                       pick_warp;
  logic                                fetch_ok, dp_free, busy_en;
  logic [BW-1:0]                       busy_q, busy_d;

  assign fetch_busy = fetch_valid &  occ[fetch_warp];
  assign fetch_ok   = fetch_valid & ~occ[fetch_warp];
  assign dp_free    = (busy_q == '0);

  // Datapath occupancy countdown.
  always_comb begin
    busy_en = pick_valid | ~dp_free;
    if (pick_valid) busy_d = BW'(ISSUE_CYCLES - 1);
    else            busy_d = busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end

  wis_slot_buffer #(.NW(NUM_WARPS), .RW(RW), .AGE_W(AGE_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fetch_ok), .wr_warp(fetch_warp),
    .wr_src0(fetch_src0), .wr_src1(fetch_src1), .wr_dst(fetch_dst),
    .rel_en(pick_valid), .rel_warp(pick_warp),
    .occ(occ), .src0(s0), .src1(s1), .dst(dd), .age(age)
  );

  wis_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_en(pick_valid), .set_warp(pick_warp), .set_reg(dd[pick_warp]),
    .clr_en(wb_valid), .clr_warp(wb_warp), .clr_reg(wb_reg),
    .pend(pend)
  );

  wis_picker #(.NW(NUM_WARPS), .NR(NUM_REGS), .AGE_W(AGE_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .enable(dp_free),
    .occ(occ), .src0(s0), .src1(s1), .dst(dd), .age(age), .pend(pend),
    .pick_valid(pick_valid), .pick_warp(pick_warp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_src0  <= '0;
      issue_src1  <= '0;
      issue_dst   <= '0;
    end else begin
      issue_valid <= pick_valid;
      if (pick_valid) begin
        issue_warp <= pick_warp;
        issue_src0 <= s0[pick_warp];
        issue_src1 <= s1[pick_warp];
        issue_dst  <= dd[pick_warp];
      end
    end
  end

  // R5
  issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !issue_valid);

  // R10
  slot_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !occ[issue_warp]);

  // R4
  dst_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !($past(wb_valid) && $past(wb_warp) == issue_warp
                      && $past(wb_reg) == issue_dst))
      |-> pend[issue_warp][issue_dst]);

endmodule

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/100ps
module sim_warp_issue_sched;

  localparam int NW = 4;
  localparam int NR = 8;
  localparam int WW = 2;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [WW-1:0] fetch_warp = '0;
  logic [RW-1:0] fetch_src0 = '0, fetch_src1 = '0, fetch_dst = '0;
  logic fetch_busy;
  logic wb_valid = 1'b0;
  logic [WW-1:0] wb_warp = '0;
  logic [RW-1:0] wb_reg = '0;
  logic issue_valid;
  logic [WW-1:0] issue_warp;
  logic [RW-1:0] issue_src0, issue_src1, issue_dst;

  always #2.5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .AGE_W(3), .ISSUE_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_warp(fetch_warp),
    .fetch_src0(fetch_src0), .fetch_src1(fetch_src1), .fetch_dst(fetch_dst),
    .fetch_busy(fetch_busy),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_src0(issue_src0), .issue_src1(issue_src1), .issue_dst(issue_dst)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int cyc = 0;
  int n_log = 0;
  int lw[64], ls0[64], ls1[64], ld[64], lc[64];

  // Issue log, sampled 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (issue_valid && n_log < 64) begin
      lw[n_log]  = int'(issue_warp);
      ls0[n_log] = int'(issue_src0);
      ls1[n_log] = int'(issue_src1);
      ld[n_log]  = int'(issue_dst);
      lc[n_log]  = cyc;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one fetch at the current negedge; returns the edge count and fetch_busy.
  task automatic do_fetch(input int w, input int a, input int b, input int d,
                          output int c, output bit busy);
    fetch_valid = 1'b1;
    fetch_warp  = WW'(w);
    fetch_src0  = RW'(a);
    fetch_src1  = RW'(b);
    fetch_dst   = RW'(d);
    c = cyc;
    #1;
    busy = fetch_busy;
    tk(1);
    fetch_valid = 1'b0;
  endtask

  task automatic do_wb(input int w, input int r, output int c);
    wb_valid = 1'b1;
    wb_warp  = WW'(w);
    wb_reg   = RW'(r);
    c = cyc;
    tk(1);
    wb_valid = 1'b0;
  endtask

  task automatic chk_entry(input int i, input string req, input int w, input int a,
                           input int b, input int d, input int c);
    chk(n_log > i, req, n_log, i + 1);
    if (n_log > i) begin
      chk(lw[i] == w, req, lw[i], w);
      chk(ls0[i] == a && ls1[i] == b && ld[i] == d, req, ls0[i]*100 + ls1[i]*10 + ld[i],
          a*100 + b*10 + d);
      chk(lc[i] == c, req, lc[i], c);
    end
  endtask

  initial begin
    int c, c2, base;
    bit bz;
    tk(3);
    rst_n = 1'b1;
    tk(3);

    // R1: nothing issues out of reset.
    chk(n_log == 0 && issue_valid == 1'b0, "R1", n_log, 0);

    // R1 / R8 / R10: first fetch accepted, issues two edges later with its fields.
    do_fetch(0, 1, 2, 3, c, bz);
    chk(bz == 1'b0, "R1", int'(bz), 0);
    tk(3);
    chk_entry(0, "R8", 0, 1, 2, 3, c + 2);
    chk(n_log == 1 && issue_valid == 1'b0, "R10", n_log, 1);

    // R3 sweep: r3 of warp 0 pending, probe each register position.
    for (int p = 0; p < 3; p++) begin
      int a, b, d;
      if (p > 0) begin
        do_fetch(0, 0, 0, 3, c, bz);
        tk(6);
      end
      a = (p == 0) ? 3 : 1;
      b = (p == 1) ? 3 : 2;
      d = (p == 2) ? 3 : 2;
      do_fetch(0, a, b, d, c, bz);
      base = n_log;
      tk(10);
      chk(n_log == base, "R3", n_log - base, 0);
      if (p == 0) begin
        // R2: slot occupied, second fetch refused and dropped.
        do_fetch(0, 7, 7, 7, c, bz);
        chk(bz == 1'b1, "R2", int'(bz), 1);
      end
      do_wb(0, 3, c2);
      tk(3);
      chk_entry(base, (p == 0) ? "R2" : "R3", 0, a, b, d, c2 + 2);
      do_wb(0, d, c2);
      tk(5);
    end

    // R4: writeback in the issue cycle wins over the pending mark.
    do_fetch(0, 0, 0, 5, c, bz);
    wb_valid = 1'b1; wb_warp = 2'd0; wb_reg = 3'd5;
    tk(1);
    wb_valid = 1'b0;
    tk(5);
    chk(lc[n_log-1] == c + 2 && ld[n_log-1] == 5, "R4", lc[n_log-1], c + 2);
    base = n_log;
    do_fetch(0, 5, 0, 0, c, bz);
    tk(3);
    chk_entry(base, "R4", 0, 5, 0, 0, c + 2);
    do_wb(0, 0, c2);
    tk(5);

    // R9: warp 1 waits on r6 while warps 2 and 3 proceed.
    do_fetch(1, 0, 0, 6, c, bz);
    tk(6);
    do_fetch(1, 6, 0, 1, c, bz);
    base = n_log;
    tk(2);
    do_fetch(2, 0, 0, 7, c, bz);
    tk(6);
    chk_entry(base, "R9", 2, 0, 0, 7, c + 2);
    do_fetch(3, 6, 6, 1, c, bz);
    tk(1);
    chk_entry(base + 1, "R9", 3, 6, 6, 1, c + 2);

    // R5 / R6 / R7: release warp 1 (older), fetch warps 0 and 2 (younger, tied).
    wb_valid = 1'b1; wb_warp = 2'd1; wb_reg = 3'd6;
    do_fetch(0, 1, 2, 4, c2, bz);
    wb_valid = 1'b0;
    do_fetch(2, 1, 2, 4, c2, bz);
    tk(14);
    chk_entry(base + 2, "R6", 1, 6, 0, 1, c + 6);
    chk_entry(base + 3, "R7", 2, 1, 2, 4, c + 10);
    chk_entry(base + 4, "R7", 0, 1, 2, 4, c + 14);
    chk(n_log == base + 5, "R5", n_log - base, 5);
    if (n_log >= base + 5)
      chk(lc[base+3] - lc[base+2] == 4 && lc[base+4] - lc[base+3] == 4, "R5",
          lc[base+4] - lc[base+2], 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule